// File: doc/BRIEF.md
# Multi-Bank GPIO Pin Control Registers

This block is the register side of a 93-pin general-purpose I/O port. Software reaches it through a simple word-addressed read/write bus. Each per-pin function has its own group of bank words, and each word covers up to 32 pins. The functions are output enable, input enable, output data, input data, pull-up, pull-down and open-drain. From the register state the block works out, for every pin, the value to drive, whether to drive it, and whether either bias resistor is on. The pin levels coming back from the pads pass through a two-stage synchroniser before software can read them.

Input enable takes priority over output enable, so a pin set as an input never drives. A pin in open-drain mode never drives high: a data value of 1 releases the pad and a data value of 0 pulls it low. The bias bits are independent of each other and of the direction bits. The last bank holds only 29 pins.

Top module: `gpio_pin_ctrl`

## Requirements
- R1: After synchronous reset every writable register reads 0, and pad_oe, pad_out, pad_pu and pad_pd are all 0.
- R2: Word address 0x100 + 4*g + b (byte offset 0x400 + 0x10*g + 4*b) selects group g and bank b. Bank b covers pins 32*b to 32*b+31, and pin 32*b+i is bit i. The groups are 0 output enable, 1 input enable, 2 output data, 3 input data, 4 pull-up, 5 pull-down and 6 open-drain. Read data appears on bus_rdata with bus_rvalid high on the cycle after bus_rd_en.
- R3: A pin drives (pad_oe=1) only when its output-enable bit is 1 and its input-enable bit is 0. A set input-enable bit stops the pin from driving whatever the other bits hold.
- R4: With the open-drain bit at 0, pad_out follows the pin's output-data bit.
- R5: With the open-drain bit at 1, an output-data bit of 1 releases the pin (pad_oe=0). An output-data bit of 0 drives it low (pad_oe=1 when enabled, pad_out=0).
- R6: pad_pu and pad_pd follow the pull-up and pull-down bits independently. Both may be on at once, and clearing both removes the bias.
- R7: A pad_in level appears in the input-data group through two flip-flops. A read whose capture edge is the first or second edge after the change returns the old level, and the third returns the new one. Writes to the input-data group change nothing.
- R8: Bits 29 to 31 of bank 2 read as 0 in every group and ignore writes.
- R9: Writes to an address outside groups 0 to 6 or banks 0 to 2 change no register, and reads of such an address return 0.
- R10: A write to one bank word changes only the pins of that bank.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr_en | input | 1 | Write strobe for one cycle |
| bus_rd_en | input | 1 | Read strobe for one cycle |
| bus_addr | input | 9 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | High the cycle after a read strobe |
| pad_in | input | 93 | Pin levels from the pads, asynchronous |
| pad_out | output | 93 | Value to drive per pin |
| pad_oe | output | 93 | Drive enable per pin |
| pad_pu | output | 93 | Pull-up enable per pin |
| pad_pd | output | 93 | Pull-down enable per pin |

## Verification
The bench sets input enable and output enable together on a pin. A design that let output enable win would drive a pin software meant to listen on. Open-drain pins are checked with both data values: a wrong design would drive a released line high, or fail to pull it low. The synchroniser is checked by back-to-back reads straddling a pad change. One flop too few or too many moves the cycle in which the new level shows. Writes of all ones are aimed at bank 2, at the input-data group and at unmapped words (group 7, bank 3 and addresses below the group base). A decoder that aliased them or a mask that was missing would show stray bits on read-back or on the pads.

// File: rtl/gpio_pin_pkg.sv
package gpio_pin_pkg;

    localparam int WORD_W = 32;

    // Function groups, selected by word address bits [5:2]
    typedef enum logic [3:0] {
        GRP_OUT_EN  = 4'd0,
        GRP_IN_EN   = 4'd1,
        GRP_DOUT    = 4'd2,
        GRP_DIN     = 4'd3,
        GRP_PULL_UP = 4'd4,
        GRP_PULL_DN = 4'd5,
        GRP_OPEN_DR = 4'd6
    } grp_e;

    localparam logic [3:0] LAST_GRP = 4'd6;

    // Decoded bus address
    typedef struct packed {
        logic       hit;    // address maps to a real bank word
        logic       wr_ok;  // hit and writable group
        grp_e       grp;
        logic [1:0] bank;
    } dec_t;

    // Control state of one pin
    typedef struct packed {
        logic out_en;
        logic in_en;
        logic dout;
        logic pull_up;
        logic pull_dn;
        logic open_dr;
    } pin_ctrl_t;

    // Pad-side controls of one pin
    typedef struct packed {
        logic drv;
        logic en;
        logic pu;
        logic pd;
    } pad_ctl_t;

    function automatic int bank_count(input int pins);
        return (pins + WORD_W - 1) / WORD_W;
    endfunction

    // Input enable wins over output enable; open-drain turns a 1 into release
    function automatic pad_ctl_t resolve_pin(input pin_ctrl_t c);
        pad_ctl_t r;
        logic     want_drive;
        want_drive = c.out_en & ~c.in_en;
        r.en  = want_drive & ~(c.open_dr & c.dout);
        r.drv = c.dout & ~c.open_dr;
        r.pu  = c.pull_up;
        r.pd  = c.pull_dn;
        return r;
    endfunction

endpackage

// File: rtl/gpio_addr_dec.sv
module gpio_addr_dec
    import gpio_pin_pkg::*;
#(
    parameter int              ADDR_W    = 9,
    parameter int              NUM_BANKS = 3,
    parameter logic [ADDR_W-1:0] GRP_BASE = 'h100
) (
    input  logic [ADDR_W-1:0] addr,
    output dec_t              dec
);

    localparam int HI_LSB = 6;

    logic [3:0] grp_raw;
    logic [1:0] bank_raw;
    logic       base_ok;
    logic       grp_ok;
    logic       bank_ok;

    always_comb begin
        grp_raw  = addr[5:2];
        bank_raw = addr[1:0];
        base_ok  = (addr[ADDR_W-1:HI_LSB] == GRP_BASE[ADDR_W-1:HI_LSB]);
        grp_ok   = (grp_raw <= LAST_GRP);
        bank_ok  = (int'(bank_raw) < NUM_BANKS);

        dec.hit   = base_ok & grp_ok & bank_ok;
        dec.grp   = grp_e'(grp_raw);
        dec.bank  = bank_raw;
        dec.wr_ok = dec.hit & (grp_raw != GRP_DIN);
    end

endmodule

// File: rtl/gpio_ctrl_regs.sv
module gpio_ctrl_regs
    import gpio_pin_pkg::*;
#(
    parameter int NUM_PINS  = 93,
    parameter int NUM_BANKS = 3
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_en,
    input  logic                  rd_en,
    input  dec_t                  dec,
    input  logic [WORD_W-1:0]     wdata,
    input  logic [NUM_PINS-1:0]   din,
    output pin_ctrl_t [NUM_PINS-1:0] ctrl,
    output logic [WORD_W-1:0]     rdata,
    output logic                  rvalid
);

    localparam int LAST_BITS = NUM_PINS - (NUM_BANKS - 1) * WORD_W;

    logic [NUM_PINS-1:0] oe_q, ie_q, do_q, pu_q, pd_q, od_q;
    logic [NUM_PINS-1:0] sel_vec;
    logic [WORD_W-1:0]   rd_word;

    // One storage cell per pin and function; only pins that exist get flops
    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        localparam int BANK = p / WORD_W;
        localparam int BIT  = p % WORD_W;

        always_ff @(posedge clk) begin
            if (rst) begin
                oe_q[p] <= 1'b0;
                ie_q[p] <= 1'b0;
                do_q[p] <= 1'b0;
                pu_q[p] <= 1'b0;
                pd_q[p] <= 1'b0;
                od_q[p] <= 1'b0;
            end else if (wr_en && dec.wr_ok && (dec.bank == 2'(BANK))) begin
                case (dec.grp)
                    GRP_OUT_EN:  oe_q[p] <= wdata[BIT];
                    GRP_IN_EN:   ie_q[p] <= wdata[BIT];
                    GRP_DOUT:    do_q[p] <= wdata[BIT];
                    GRP_PULL_UP: pu_q[p] <= wdata[BIT];
                    GRP_PULL_DN: pd_q[p] <= wdata[BIT];
                    GRP_OPEN_DR: od_q[p] <= wdata[BIT];
                    default: ;
                endcase
            end
        end

        assign ctrl[p] = {oe_q[p], ie_q[p], do_q[p], pu_q[p], pd_q[p], od_q[p]};
    end

    // Read path: pick the function vector, then slice out the bank word
    always_comb begin
        case (dec.grp)
            GRP_OUT_EN:  sel_vec = oe_q;
            GRP_IN_EN:   sel_vec = ie_q;
            GRP_DOUT:    sel_vec = do_q;
            GRP_DIN:     sel_vec = din;
            GRP_PULL_UP: sel_vec = pu_q;
            GRP_PULL_DN: sel_vec = pd_q;
            GRP_OPEN_DR: sel_vec = od_q;
            default:     sel_vec = '0;
        endcase
        rd_word = '0;
        for (int i = 0; i < WORD_W; i++) begin
            if (dec.hit && (int'(dec.bank) * WORD_W + i < NUM_PINS)) begin
                rd_word[i] = sel_vec[int'(dec.bank) * WORD_W + i];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata  <= '0;
            rvalid <= 1'b0;
        end else begin
            rvalid <= rd_en;
            rdata  <= rd_en ? rd_word : '0;
        end
    end

    // R2: every read strobe is answered on the next cycle
    p_rvalid_next_r2: assert property (@(posedge clk) disable iff (rst)
        rd_en |=> rvalid);

    // R9: unmapped reads return zero
    p_unmapped_rd_zero_r9: assert property (@(posedge clk) disable iff (rst)
        (rd_en && !dec.hit) |=> (rdata == '0));

    // R9: unmapped writes leave all control state alone
    p_unmapped_wr_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !dec.hit) |=> ($stable(oe_q) && $stable(ie_q) && $stable(do_q)
                                 && $stable(pu_q) && $stable(pd_q) && $stable(od_q)));

    // R7: the input-data group is read-only
    p_din_wr_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (wr_en && dec.hit && dec.grp == GRP_DIN) |=> ($stable(oe_q) && $stable(ie_q)
            && $stable(do_q) && $stable(pu_q) && $stable(pd_q) && $stable(od_q)));

    // R8: missing pins of the last bank always read as zero
    if (LAST_BITS < WORD_W) begin : g_last_mask
        p_last_bank_hi_zero_r8: assert property (@(posedge clk) disable iff (rst)
            (rd_en && dec.hit && dec.bank == 2'(NUM_BANKS - 1))
                |=> (rdata[WORD_W-1:LAST_BITS] == '0));
    end

endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int WIDTH = 93
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    logic [WIDTH-1:0] meta_q;
    logic [WIDTH-1:0] sync_q;
    logic [1:0]       warm_q;   // marks two clean cycles since reset for the check

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= '0;
            sync_q <= '0;
            warm_q <= '0;
        end else begin
            meta_q <= async_in;
            sync_q <= meta_q;
            warm_q <= {warm_q[0], 1'b1};
        end
    end

    assign sync_out = sync_q;

    // R7: output lags the pad by exactly two clock edges
    p_sync_latency_r7: assert property (@(posedge clk) disable iff (rst)
        warm_q[1] |-> (sync_q == $past(async_in, 2)));

endmodule

// File: rtl/gpio_pin_ctrl.sv
module gpio_pin_ctrl
    import gpio_pin_pkg::*;
#(
    parameter int NUM_PINS = 93,
    parameter int ADDR_W   = 9
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                bus_wr_en,
    input  logic                bus_rd_en,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [31:0]         bus_wdata,
    output logic [31:0]         bus_rdata,
    output logic                bus_rvalid,
    input  logic [NUM_PINS-1:0] pad_in,
    output logic [NUM_PINS-1:0] pad_out,
    output logic [NUM_PINS-1:0] pad_oe,
    output logic [NUM_PINS-1:0] pad_pu,
    output logic [NUM_PINS-1:0] pad_pd
);

    localparam int NUM_BANKS = bank_count(NUM_PINS);

    dec_t                    dec;
    pin_ctrl_t [NUM_PINS-1:0] ctrl;
    logic [NUM_PINS-1:0]     din_sync;
    logic [NUM_PINS-1:0]     ie_vec;
    logic [NUM_PINS-1:0]     od_vec;

    gpio_addr_dec #(
        .ADDR_W    (ADDR_W),
        .NUM_BANKS (NUM_BANKS)
    ) u_dec (
        .addr (bus_addr),
        .dec  (dec)
    );

    gpio_in_sync #(
        .WIDTH (NUM_PINS)
    ) u_sync (
        .clk      (clk),
        .rst      (rst),
        .async_in (pad_in),
        .sync_out (din_sync)
    );

    gpio_ctrl_regs #(
        .NUM_PINS  (NUM_PINS),
        .NUM_BANKS (NUM_BANKS)
    ) u_regs (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (bus_wr_en),
        .rd_en  (bus_rd_en),
        .dec    (dec),
        .wdata  (bus_wdata),
        .din    (din_sync),
        .ctrl   (ctrl),
        .rdata  (bus_rdata),
        .rvalid (bus_rvalid)
    );

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pad
        pad_ctl_t pc;
        assign pc         = resolve_pin(ctrl[p]);
        assign pad_out[p] = pc.drv;
        assign pad_oe[p]  = pc.en;
        assign pad_pu[p]  = pc.pu;
        assign pad_pd[p]  = pc.pd;
        assign ie_vec[p]  = ctrl[p].in_en;
        assign od_vec[p]  = ctrl[p].open_dr;
    end

    // R3: a pin set as input is never driven
    p_input_not_driven_r3: assert property (@(posedge clk) disable iff (rst)
        ((pad_oe & ie_vec) == '0));

    // R5: an open-drain pin never drives a high level
    p_od_never_high_r5: assert property (@(posedge clk) disable iff (rst)
        ((pad_oe & pad_out & od_vec) == '0));

endmodule

// File: tb/gpio_pin_ctrl_tb_top.sv
module gpio_pin_ctrl_tb_top;

    localparam int NP = 93;
    localparam int G_OE = 0, G_IE = 1, G_DO = 2, G_DI = 3, G_PU = 4, G_PD = 5, G_OD = 6;

    logic          clk = 1'b0;
    logic          rst;
    logic          bus_wr_en, bus_rd_en;
    logic [8:0]    bus_addr;
    logic [31:0]   bus_wdata, bus_rdata;
    logic          bus_rvalid;
    logic [NP-1:0] pad_in, pad_out, pad_oe, pad_pu, pad_pd;

    logic [NP-1:0] m_oe, m_ie, m_do, m_pu, m_pd, m_od;
    int            n_run, n_fail;
    bit            done;

    always #5 clk = ~clk;

    gpio_pin_ctrl dut_i (
        .clk(clk), .rst(rst),
        .bus_wr_en(bus_wr_en), .bus_rd_en(bus_rd_en), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
        .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
        .pad_pu(pad_pu), .pad_pd(pad_pd)
    );

    task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [8:0] ga(input int g, input int b);
        return 9'(9'h100 + g * 4 + b);
    endfunction

    // All bus tasks start and end at a falling edge
    task automatic bus_wr(input logic [8:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_wr_en = 1'b1;
        @(posedge clk); @(negedge clk);
        bus_wr_en = 1'b0;
    endtask

    task automatic bus_rd(input logic [8:0] a, output logic [31:0] d, output logic v);
        bus_addr = a; bus_rd_en = 1'b1;
        @(posedge clk); @(negedge clk);
        bus_rd_en = 1'b0;
        d = bus_rdata; v = bus_rvalid;
    endtask

    task automatic model_set(input int g, input int b, input logic [31:0] d);
        for (int i = 0; i < 32; i++) begin
            int idx;
            idx = b * 32 + i;
            if (idx < NP) begin
                case (g)
                    G_OE: m_oe[idx] = d[i];
                    G_IE: m_ie[idx] = d[i];
                    G_DO: m_do[idx] = d[i];
                    G_PU: m_pu[idx] = d[i];
                    G_PD: m_pd[idx] = d[i];
                    G_OD: m_od[idx] = d[i];
                    default: ;
                endcase
            end
        end
    endtask

    task automatic cfg(input int g, input int b, input logic [31:0] d);
        bus_wr(ga(g, b), d);
        model_set(g, b, d);
    endtask

    function automatic logic [NP-1:0] model_vec(input int g);
        case (g)
            G_OE: return m_oe;
            G_IE: return m_ie;
            G_DO: return m_do;
            G_DI: return pad_in;
            G_PU: return m_pu;
            G_PD: return m_pd;
            default: return m_od;
        endcase
    endfunction

    function automatic logic [31:0] word_of(input logic [NP-1:0] v, input int b);
        logic [31:0] w;
        w = '0;
        for (int i = 0; i < 32; i++) begin
            if (b * 32 + i < NP) w[i] = v[b * 32 + i];
        end
        return w;
    endfunction

    task automatic check_pads(input string tag);
        logic [NP-1:0] e_oe, e_out;
        e_oe  = m_oe & ~m_ie & ~(m_od & m_do);
        e_out = m_do & ~m_od;
        chk({tag, " pad_oe"}, pad_oe, e_oe);
        chk({tag, " pad_out"}, pad_out, e_out);
        chk({tag, " pad_pu"}, pad_pu, m_pu);
        chk({tag, " pad_pd"}, pad_pd, m_pd);
    endtask

    task automatic check_reads(input string tag);
        logic [31:0] d;
        logic        v;
        for (int g = 0; g <= 6; g++) begin
            for (int b = 0; b < 3; b++) begin
                bus_rd(ga(g, b), d, v);
                chk($sformatf("%s read g%0d b%0d", tag, g, b), d, word_of(model_vec(g), b));
            end
        end
    endtask

    task automatic clear_all();
        for (int g = 0; g <= 6; g++) begin
            if (g != G_DI) for (int b = 0; b < 3; b++) cfg(g, b, 32'h0);
        end
    endtask

    task automatic t_reset();
        check_pads("R1");
        check_reads("R1");
    endtask

    task automatic t_map();
        logic [31:0] d;
        logic        v;
        for (int g = 0; g <= 6; g++) begin
            if (g != G_DI) begin
                for (int b = 0; b < 3; b++) begin
                    cfg(g, b, (32'h9E37_79B9 * (g + 1)) ^ (32'h1357_0000 * (b + 1)) ^ 32'hE000_0000);
                end
            end
        end
        check_reads("R2 R8");
        check_pads("R2 R10");
        bus_rd(ga(G_OE, 1), d, v);
        chk("R2 rvalid after read strobe", v, 1'b1);
        bus_rd(ga(G_PU, 2), d, v);
        chk("R8 bank2 bits 31:29 zero", d[31:29], 3'b000);
        clear_all();
    endtask

    task automatic t_bank_iso();
        cfg(G_PU, 1, 32'hFFFF_FFFF);
        chk("R10 only bank1 pull-ups on", pad_pu, {29'h0, 32'hFFFF_FFFF, 32'h0});
        check_pads("R10");
        cfg(G_PU, 1, 32'h0);
    endtask

    task automatic t_dir();
        cfg(G_OE, 0, 32'h8);
        cfg(G_DO, 0, 32'h8);
        chk("R3 output pin drives", pad_oe[3], 1'b1);
        chk("R4 push-pull value", pad_out[3], 1'b1);
        cfg(G_IE, 0, 32'h8);
        chk("R3 input enable blocks drive", pad_oe[3], 1'b0);
        cfg(G_OE, 0, 32'h0);
        cfg(G_IE, 0, 32'h0);
        chk("R3 no enable no drive", pad_oe[3], 1'b0);
        check_pads("R3");
    endtask

    task automatic t_od();
        cfg(G_OE, 1, 32'h300);
        cfg(G_DO, 1, 32'h300);
        cfg(G_OD, 1, 32'h100);
        chk("R5 open-drain 1 releases", pad_oe[40], 1'b0);
        chk("R4 neighbour push-pull drives", pad_oe[41], 1'b1);
        chk("R4 neighbour push-pull high", pad_out[41], 1'b1);
        cfg(G_DO, 1, 32'h200);
        chk("R5 open-drain 0 drives", pad_oe[40], 1'b1);
        chk("R5 open-drain 0 is low", pad_out[40], 1'b0);
        check_pads("R5");
    endtask

    task automatic t_pull();
        cfg(G_PU, 2, 32'h40);
        cfg(G_PD, 2, 32'h40);
        chk("R6 pull-up on", pad_pu[70], 1'b1);
        chk("R6 pull-down on", pad_pd[70], 1'b1);
        cfg(G_PU, 2, 32'h0);
        chk("R6 pull-down stays", pad_pd[70], 1'b1);
        cfg(G_PD, 2, 32'h0);
        chk("R6 bias off", {pad_pu[70], pad_pd[70]}, 2'b00);
    endtask

    task automatic t_sync();
        logic [31:0] d;
        logic        v;
        pad_in[5] = 1'b1;
        bus_rd(ga(G_DI, 0), d, v);
        chk("R7 first edge old level", d[5], 1'b0);
        bus_rd(ga(G_DI, 0), d, v);
        chk("R7 second edge old level", d[5], 1'b0);
        bus_rd(ga(G_DI, 0), d, v);
        chk("R7 third edge new level", d[5], 1'b1);
        pad_in[92] = 1'b1;
        pad_in[33] = 1'b1;
        repeat (3) @(negedge clk);
        bus_rd(ga(G_DI, 2), d, v);
        chk("R7 last pin read", d, 32'h1000_0000);
        bus_wr(ga(G_DI, 0), 32'hFFFF_FFFF);
        bus_wr(ga(G_DI, 2), 32'hFFFF_FFFF);
        check_reads("R7");
        check_pads("R7");
    endtask

    task automatic t_unmapped();
        logic [31:0] d;
        logic        v;
        bus_wr(9'h000, 32'hFFFF_FFFF);
        bus_wr(9'h11C, 32'hFFFF_FFFF);
        bus_wr(9'h103, 32'hFFFF_FFFF);
        bus_wr(9'h1C0, 32'hFFFF_FFFF);
        bus_rd(9'h11C, d, v);
        chk("R9 group 7 reads zero", d, 32'h0);
        bus_rd(9'h103, d, v);
        chk("R9 bank 3 reads zero", d, 32'h0);
        bus_rd(9'h000, d, v);
        chk("R9 low address reads zero", d, 32'h0);
        check_reads("R9");
        check_pads("R9");
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        n_run = 0; n_fail = 0; done = 0;
        rst = 1'b1; bus_wr_en = 1'b0; bus_rd_en = 1'b0;
        bus_addr = '0; bus_wdata = '0; pad_in = '0;
        m_oe = '0; m_ie = '0; m_do = '0; m_pu = '0; m_pd = '0; m_od = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        t_reset();
        t_map();
        t_bank_iso();
        t_dir();
        t_od();
        t_pull();
        t_sync();
        t_unmapped();
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule